// File: doc/BRIEF.md
# Attribute-Colour Pixel Generator

This block turns a monochrome pixel stream into 4-bit RGBI colour. Each character clock, the display fetch reads two bytes together. The first byte goes through the glyph path, which lies outside this block. That path sends this block one serial pixel bit per pixel clock, at 8 MHz, so a 1 MHz character clock gives 40 colour columns. The second byte is an attribute byte. It holds a foreground colour in its upper nibble and a background colour in its lower nibble. Every pixel of an 8x8 character cell therefore shares one colour pair.

The attribute byte arrives already latched at fetch time. The fetch for the next cell happens while the current glyph row is still shifting out. For that reason the block holds its own copy of the attribute. This copy is updated only by the load strobe that also loads the external glyph shift register, so the colour changes exactly at character boundaries. For each pixel, the pixel bit selects a nibble of the held attribute. The result is registered onto the RGBI output. Outside display enable the output is forced to black.

Top module: `attr_pixel_gen`

## Requirements
- R1: While rst_ni is low, rgbi_o is 0000 at once (asynchronous reset) and the held attribute is cleared to 0x00. After release and before any load, rgbi_o therefore stays 0000 for every pixel value.
- R2: With de_i high and pix_i = 1 in a cycle, rgbi_o after the next rising edge equals bits [7:4] of the held attribute (foreground).
- R3: With de_i high and pix_i = 0 in a cycle, rgbi_o after the next rising edge equals bits [3:0] of the held attribute (background).
- R4: A change of attr_i while load_i is low does not affect the held attribute, so the colours on rgbi_o do not change.
- R5: On a rising edge with load_i high, the held attribute takes the value of attr_i. The pixel presented in that same cycle still uses the previous attribute. The new pair applies from the following pixel onward.
- R6: With de_i low in a cycle, rgbi_o after the next rising edge is 0000, whatever pix_i and the held attribute are.
- R7: The held attribute keeps its value over any number of pixels until the next load, and loads in consecutive cycles each take effect.
- R8: rgbi_o changes only on a rising clock edge, one cycle after the pixel bit and display enable that produce it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Character-boundary strobe, shared with the glyph shifter load |
| attr_i | input | 8 | Attribute byte latched at fetch: fg [7:4], bg [3:0] |
| pix_i | input | 1 | Serial glyph pixel bit; 1 picks foreground |
| de_i | input | 1 | Display enable, aligned with pix_i |
| rgbi_o | output | 4 | Registered RGBI colour |

## Verification
The hardest case to reach is a fetch that updates attr_i in the middle of a cell while the previous cell's pixels are still going out. Only a correct delay register keeps the old colours on the screen in that case. The stimulus changes attr_i with load_i low in the middle of a glyph row and checks that the foreground and background stay the same. It then raises load_i on the very cycle attr_i changes, to show that the pixel in that cycle still uses the old pair. Back-to-back loads and an asynchronous reset taken during active display cover the remaining edges.

// File: rtl/acp_pkg.sv
package acp_pkg;
  parameter int unsigned COLOR_W = 4;
  localparam int unsigned ATTR_W = 2 * COLOR_W;
endpackage

// File: rtl/acp_attr_delay.sv
module acp_attr_delay #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] attr_i,
  output logic [W-1:0] attr_o
);
  // Holds the pair for the glyph row currently shifting, not the next fetch.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     attr_o <= '0;
    else if (load_i) attr_o <= attr_i;
  end
endmodule

// File: rtl/acp_nibble_sel.sv
module acp_nibble_sel #(
  parameter int unsigned COLOR_W  = 4,
  parameter bit          FG_UPPER = 1'b1,
  localparam int unsigned ATTR_W  = 2 * COLOR_W
) (
  input  logic [ATTR_W-1:0]  attr_i,
  input  logic               pix_i,
  output logic [COLOR_W-1:0] color_o
);
  logic [COLOR_W-1:0] hi_nib, lo_nib;
  assign hi_nib = attr_i[ATTR_W-1 -: COLOR_W];
  assign lo_nib = attr_i[COLOR_W-1:0];

  generate
    if (FG_UPPER) begin : g_fg_hi
      assign color_o = pix_i ? hi_nib : lo_nib;
    end else begin : g_fg_lo
      assign color_o = pix_i ? lo_nib : hi_nib;
    end
  endgenerate
endmodule

// File: rtl/acp_out_stage.sv
module acp_out_stage #(
  parameter int unsigned COLOR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               de_i,
  input  logic [COLOR_W-1:0] color_i,
  output logic [COLOR_W-1:0] rgbi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgbi_o <= '0;
    else         rgbi_o <= de_i ? color_i : '0;
  end
endmodule

// File: rtl/attr_pixel_gen.sv
module attr_pixel_gen #(
  parameter int unsigned COLOR_W = acp_pkg::COLOR_W,
  localparam int unsigned ATTR_W = 2 * COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ATTR_W-1:0]  attr_i,
  input  logic               pix_i,
  input  logic               de_i,
  output logic [COLOR_W-1:0] rgbi_o
);
  logic [ATTR_W-1:0]  attr_q;
  logic [COLOR_W-1:0] color_d;

  acp_attr_delay #(.W(ATTR_W)) attr_dly_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .attr_i (attr_i),
    .attr_o (attr_q)
  );

  acp_nibble_sel #(.COLOR_W(COLOR_W), .FG_UPPER(1'b1)) nib_sel_i (
    .attr_i  (attr_q),
    .pix_i   (pix_i),
    .color_o (color_d)
  );

  acp_out_stage #(.COLOR_W(COLOR_W)) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .de_i    (de_i),
    .color_i (color_d),
    .rgbi_o  (rgbi_o)
  );
endmodule

// File: rtl/attr_pixel_gen_chk.sv
module attr_pixel_gen_chk #(
  parameter int unsigned COLOR_W = 4,
  localparam int unsigned ATTR_W = 2 * COLOR_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [ATTR_W-1:0]  attr_i,
  input logic               pix_i,
  input logic               de_i,
  input logic [COLOR_W-1:0] rgbi_o,
  input logic [ATTR_W-1:0]  attr_q
);
  p_fg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && pix_i) |=> rgbi_o == $past(attr_q[ATTR_W-1 -: COLOR_W]));

  p_bg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && !pix_i) |=> rgbi_o == $past(attr_q[COLOR_W-1:0]));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(attr_q));

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> attr_q == $past(attr_i));

  p_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |=> rgbi_o == '0);
endmodule

bind attr_pixel_gen attr_pixel_gen_chk #(.COLOR_W(COLOR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .attr_i (attr_i),
  .pix_i  (pix_i),
  .de_i   (de_i),
  .rgbi_o (rgbi_o),
  .attr_q (attr_q)
);

// File: tb/attr_pixel_gen_tb_top.sv
module attr_pixel_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] attr_i = 8'h00;
  logic       pix_i = 1'b0;
  logic       de_i = 1'b0;
  logic [3:0] rgbi_o;

  attr_pixel_gen dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .attr_i (attr_i),
    .pix_i  (pix_i),
    .de_i   (de_i),
    .rgbi_o (rgbi_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] m_attr = 8'h00;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rgbi_o=%h expected %h", req, act, exp);
    end
  endtask

  // Driver: apply one pixel cycle and queue the colour due after the next edge.
  task automatic px(input logic p, input logic d, input logic ld,
                    input logic [7:0] a, input string req);
    item_t it;
    @(negedge clk_i);
    pix_i = p; de_i = d; load_i = ld; attr_i = a;
    it.exp = d ? (p ? m_attr[7:4] : m_attr[3:0]) : 4'h0;
    it.req = req;
    sb_q.push_back(it);
    if (ld) m_attr = a;
  endtask

  task automatic row(input logic [7:0] bits, input logic [7:0] a, input string req);
    for (int i = 7; i >= 0; i--) px(bits[i], 1'b1, 1'b0, a, req);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(rgbi_o, it.exp, it.req);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: rgbi_o=%h expected completion", rgbi_o);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    check(rgbi_o, 4'h0, "R1 in reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: held attribute cleared, so both pixel values give black
    px(1'b1, 1'b1, 1'b0, 8'hFF, "R1");
    px(1'b0, 1'b1, 1'b0, 8'hFF, "R1");
    // R5: load in this cycle, pixel still uses old pair (0x00)
    px(1'b1, 1'b1, 1'b1, 8'hA5, "R5 old pair");
    // R2/R3: fg A, bg 5
    row(8'b1011_0010, 8'hA5, "R2/R3 row A5");
    // R4: fetch changes attr_i mid-cell without load
    row(8'b0110_1101, 8'h3C, "R4 attr_i changed no load");
    // R5: load on the cycle attr_i moves; new pair applies next pixel
    px(1'b1, 1'b1, 1'b1, 8'h3C, "R5 load edge");
    px(1'b1, 1'b1, 1'b0, 8'h3C, "R5 new fg");
    px(1'b0, 1'b1, 1'b0, 8'h3C, "R5 new bg");
    // R6: blanking
    px(1'b1, 1'b0, 1'b0, 8'h3C, "R6 blank fg");
    px(1'b0, 1'b0, 1'b0, 8'h3C, "R6 blank bg");
    px(1'b1, 1'b0, 1'b1, 8'hE7, "R6 blank with load");
    px(1'b1, 1'b1, 1'b0, 8'h00, "R7 after blank load");
    // R7: back-to-back loads, each takes effect
    px(1'b1, 1'b1, 1'b1, 8'h12, "R7 b2b");
    px(1'b1, 1'b1, 1'b1, 8'h34, "R7 b2b");
    px(1'b0, 1'b1, 1'b1, 8'h56, "R7 b2b");
    px(1'b1, 1'b1, 1'b1, 8'h9F, "R7 b2b");
    // R7: long hold across many pixels
    for (int c = 0; c < 3; c++) row(8'b1100_1010 ^ 8'(c), 8'h00, "R7 hold");
    // R8: registered output, one-cycle latency on de/pix toggling
    px(1'b1, 1'b1, 1'b0, 8'h00, "R8");
    px(1'b0, 1'b0, 1'b0, 8'h00, "R8");
    px(1'b1, 1'b1, 1'b0, 8'h00, "R8");
    @(posedge clk_i);
    #3;
    // R8: output must hold between edges
    check(rgbi_o, 4'h9, "R8 stable mid-cycle");
    // R1: asynchronous reset during active display
    @(negedge clk_i);
    pix_i = 1'b1; de_i = 1'b1; load_i = 1'b0;
    #2;
    rst_ni = 1'b0;
    #1;
    check(rgbi_o, 4'h0, "R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_attr = 8'h00;
    px(1'b1, 1'b1, 1'b0, 8'hFF, "R1 attr cleared");
    px(1'b0, 1'b1, 1'b0, 8'hFF, "R1 attr cleared");
    @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule